// File: doc/BRIEF.md
# Product-Machine Automaton Equivalence Checker

This block decides whether two small deterministic finite automata accept the same language. Software first loads each machine through a write port. For every state and input symbol it writes a next-state entry and a "specified" flag. It also writes one accept bit for every state. A start strobe then supplies one start state for each machine, and the block explores the product machine breadth-first.

The search begins at the pair of start states. It follows every symbol out of each reached pair and keeps track of pairs already seen with an internal bitmap. Newly reached pairs wait in a FIFO until they are expanded. The block halts at the first pair whose members disagree on acceptance, or when the FIFO runs dry. It then reports whether the machines are equivalent. When they are not, it also reports the offending pair and its distance from the start pair.

An unspecified transition, and every transition out of the sink, leads to a per-machine sink state. The sink never accepts. Its index equals the state count.

Top module: `dfa_eq_check`

## Requirements
- R1: A `start_i` pulse while `busy_o` is low clears the previous result (`done_o`, `equiv_o` and the fail fields go to 0) and begins a new search at (`start1_i`, `start2_i`). Unless the start pair itself mismatches, `busy_o` is 1 on the following cycle.
- R2: From pair (i, j) under symbol a, the successor is (T1(a,i), T2(a,j)).
- R3: A pair fails exactly when one member accepts and the other does not, with sink states counted as non-accepting. On failure `equiv_o` = 0, and `fail_s1_o`/`fail_s2_o` give the failing pair. `fail_depth_o` gives its BFS depth, which is the number of symbols on a shortest path from the start pair.
- R4: Expansion is breadth-first. Pairs are taken in first-reached order, and within a pair symbols are taken in ascending order, one symbol per cycle. The first failing successor found in this order is the one reported.
- R5: A transition whose specified flag is 0 leads to the sink, index `N_STATES` (16 by default). The sink's successors under every symbol are the sink. A pair with both members in their sinks is not a failure. A pair with exactly one member in a sink is a failure.
- R6: A pair is queued at most once per search. When every reachable pair has been expanded without a failure, the block sets `done_o` = 1 and `equiv_o` = 1 and drives the fail fields to 0.
- R7: If the start pair itself mismatches, `done_o` rises on the cycle after the strobe, with depth 0, `equiv_o` = 0 and `busy_o` staying 0.
- R8: `done_o` and all result outputs hold their values until the next accepted `start_i`.
- R9: While `busy_o` is 1, `start_i`, `tr_we_i` and `acc_we_i` have no effect, either on the running search or on the stored tables.
- R10: After reset `busy_o`, `done_o`, `equiv_o` and the fail fields are 0. All transitions are unspecified and all accept bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tr_we_i | input | 1 | Write one transition entry |
| acc_we_i | input | 1 | Write one accept bit |
| wr_mach_i | input | 1 | Target machine (0 = first, 1 = second) |
| wr_state_i | input | 4 | Source state of the write |
| wr_sym_i | input | 2 | Symbol of the transition write |
| wr_next_i | input | 4 | Next state for the transition write |
| wr_spec_i | input | 1 | Specified flag for the transition write |
| wr_acc_i | input | 1 | Accept bit value |
| start_i | input | 1 | Start strobe |
| start1_i | input | 4 | Start state of machine 1 |
| start2_i | input | 4 | Start state of machine 2 |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | Result valid |
| equiv_o | output | 1 | Machines found equivalent |
| fail_s1_o | output | 5 | Machine-1 member of the failing pair |
| fail_s2_o | output | 5 | Machine-2 member of the failing pair |
| fail_depth_o | output | 9 | BFS depth of the failing pair |

## Verification
The bench loads a pair of machines that differ only by a permuted state encoding. A design that dropped or misrouted a successor would call such a pair non-equivalent. A design that marked pairs only when they are dequeued would still terminate, but a missing visited check would hang or overflow. Single accept-bit flips and one-sided unspecified edges must yield the exact pair and depth that a breadth-first model predicts. A design with the wrong symbol order, an off-by-one depth, or sink states treated as accepting or as equal to a real state would report a different pair or a different verdict. A mismatch at the start pair checks the depth-0 path. Writes and strobes issued mid-search, followed by a rerun, expose a block that lets them through.

// File: rtl/dfa_eq_pkg.sv
package dfa_eq_pkg;
  typedef enum logic {
    ST_IDLE,
    ST_RUN
  } srch_state_e;
endpackage

// File: rtl/dfa_eq_table.sv
module dfa_eq_table #(
  parameter int N_STATES = 16,
  parameter int N_SYM    = 4,
  localparam int SIW = $clog2(N_STATES),
  localparam int SW  = $clog2(N_STATES + 1),
  localparam int AW  = (N_SYM > 1) ? $clog2(N_SYM) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tr_we_i,
  input  logic           acc_we_i,
  input  logic [SIW-1:0] wr_state_i,
  input  logic [AW-1:0]  wr_sym_i,
  input  logic [SIW-1:0] wr_next_i,
  input  logic           wr_spec_i,
  input  logic           wr_acc_i,
  input  logic [SW-1:0]  q_state_i,
  input  logic [AW-1:0]  q_sym_i,
  input  logic [SW-1:0]  a_state_i,
  output logic [SW-1:0]  succ_o,
  output logic           acc_o
);
  localparam logic [SW-1:0] SINK = SW'(N_STATES);

  logic [SIW-1:0] nxt_q  [N_STATES][N_SYM];
  logic [N_SYM-1:0] spec_q [N_STATES];
  logic [N_STATES-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < N_STATES; s++) begin
        spec_q[s] <= '0;
        for (int a = 0; a < N_SYM; a++) nxt_q[s][a] <= '0;
      end
      acc_q <= '0;
    end else begin
      if (tr_we_i) begin
        nxt_q[wr_state_i][wr_sym_i]  <= wr_next_i;
        spec_q[wr_state_i][wr_sym_i] <= wr_spec_i;
      end
      if (acc_we_i) acc_q[wr_state_i] <= wr_acc_i;
    end
  end

  logic           q_sink;
  logic [SIW-1:0] q_idx;
  assign q_sink = (q_state_i >= SINK);
  assign q_idx  = q_state_i[SIW-1:0];

  always_comb begin
    if (q_sink || !spec_q[q_idx][q_sym_i]) succ_o = SINK;
    else                                   succ_o = SW'(nxt_q[q_idx][q_sym_i]);
  end

  // sink never accepts
  assign acc_o = (a_state_i >= SINK) ? 1'b0 : acc_q[a_state_i[SIW-1:0]];
endmodule

// File: rtl/dfa_eq_fifo.sv
module dfa_eq_fifo #(
  parameter int DEPTH = 289,
  parameter int WIDTH = 19,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             empty_o,
  output logic             single_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    rd_q, wr_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [PW-1:0] nxt_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[clr_i ? '0 : wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      rd_q  <= '0;
      wr_q  <= push_i ? PW'(1) : '0;
      cnt_q <= push_i ? CW'(1) : '0;
    end else begin
      if (push_i) wr_q <= nxt_ptr(wr_q);
      if (pop_i)  rd_q <= nxt_ptr(rd_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign dout_o   = mem_q[rd_q];
  assign empty_o  = (cnt_q == '0);
  assign single_o = (cnt_q == CW'(1));
endmodule

// File: rtl/dfa_eq_check.sv
module dfa_eq_check
  import dfa_eq_pkg::*;
#(
  parameter int N_STATES = 16,
  parameter int N_SYM    = 4,
  localparam int SIW = $clog2(N_STATES),
  localparam int SW  = $clog2(N_STATES + 1),
  localparam int AW  = (N_SYM > 1) ? $clog2(N_SYM) : 1,
  localparam int NP  = (N_STATES + 1) * (N_STATES + 1),
  localparam int DW  = $clog2(NP),
  localparam int PIW = $clog2(NP),
  localparam int EW  = 2 * SW + DW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tr_we_i,
  input  logic           acc_we_i,
  input  logic           wr_mach_i,
  input  logic [SIW-1:0] wr_state_i,
  input  logic [AW-1:0]  wr_sym_i,
  input  logic [SIW-1:0] wr_next_i,
  input  logic           wr_spec_i,
  input  logic           wr_acc_i,
  input  logic           start_i,
  input  logic [SIW-1:0] start1_i,
  input  logic [SIW-1:0] start2_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           equiv_o,
  output logic [SW-1:0]  fail_s1_o,
  output logic [SW-1:0]  fail_s2_o,
  output logic [DW-1:0]  fail_depth_o
);
  localparam logic [SW-1:0] SINK = SW'(N_STATES);

  srch_state_e   state_q;
  logic [AW-1:0] sym_q;
  logic [NP-1:0] visited_q;

  logic [EW-1:0]        head, push_dat;
  logic                 fifo_empty, fifo_single;
  logic [1:0][SW-1:0]   head_s, start_ext, a_state, succ;
  logic [1:0]           acc;
  logic [DW-1:0]        head_d;

  assign busy_o       = (state_q == ST_RUN);
  assign head_s[0]    = head[EW-1 -: SW];
  assign head_s[1]    = head[DW+SW-1 -: SW];
  assign head_d       = head[DW-1:0];
  assign start_ext[0] = SW'(start1_i);
  assign start_ext[1] = SW'(start2_i);

  for (genvar m = 0; m < 2; m++) begin : g_mach
    assign a_state[m] = busy_o ? succ[m] : start_ext[m];
    dfa_eq_table #(.N_STATES(N_STATES), .N_SYM(N_SYM)) i_tab (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tr_we_i    (tr_we_i  & ~busy_o & (wr_mach_i == 1'(m))),
      .acc_we_i   (acc_we_i & ~busy_o & (wr_mach_i == 1'(m))),
      .wr_state_i (wr_state_i),
      .wr_sym_i   (wr_sym_i),
      .wr_next_i  (wr_next_i),
      .wr_spec_i  (wr_spec_i),
      .wr_acc_i   (wr_acc_i),
      .q_state_i  (head_s[m]),
      .q_sym_i    (sym_q),
      .a_state_i  (a_state[m]),
      .succ_o     (succ[m]),
      .acc_o      (acc[m])
    );
  end

  function automatic logic [PIW-1:0] pair_idx(input logic [SW-1:0] x, input logic [SW-1:0] y);
    return PIW'(x) * PIW'(N_STATES + 1) + PIW'(y);
  endfunction

  logic           start_go, start_mism, run_mism, last_sym, new_pair, push, pop, drained;
  logic [PIW-1:0] succ_idx;
  logic [DW-1:0]  succ_d;

  assign start_go   = start_i & ~busy_o;
  assign start_mism = acc[0] ^ acc[1];
  // one-sided sink is a mismatch; sink accept reads as 0
  assign run_mism   = busy_o & (((succ[0] == SINK) ^ (succ[1] == SINK)) | (acc[0] ^ acc[1]));
  assign last_sym   = (sym_q == AW'(N_SYM - 1));
  assign succ_idx   = pair_idx(succ[0], succ[1]);
  assign succ_d     = head_d + 1'b1;
  assign new_pair   = busy_o & ~run_mism & ~visited_q[succ_idx];
  assign push       = (start_go & ~start_mism) | new_pair;
  assign push_dat   = start_go ? {start_ext[0], start_ext[1], DW'(0)}
                               : {succ[0], succ[1], succ_d};
  assign pop        = busy_o & ~run_mism & last_sym;
  assign drained    = pop & fifo_single & ~new_pair;

  dfa_eq_fifo #(.DEPTH(NP), .WIDTH(EW)) i_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start_go),
    .push_i   (push),
    .pop_i    (pop),
    .din_i    (push_dat),
    .dout_o   (head),
    .empty_o  (fifo_empty),
    .single_o (fifo_single)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      sym_q        <= '0;
      visited_q    <= '0;
      done_o       <= 1'b0;
      equiv_o      <= 1'b0;
      fail_s1_o    <= '0;
      fail_s2_o    <= '0;
      fail_depth_o <= '0;
    end else if (start_go) begin
      visited_q <= '0;
      visited_q[pair_idx(start_ext[0], start_ext[1])] <= 1'b1;
      sym_q        <= '0;
      equiv_o      <= 1'b0;
      fail_depth_o <= '0;
      done_o       <= start_mism;
      fail_s1_o    <= start_mism ? start_ext[0] : '0;
      fail_s2_o    <= start_mism ? start_ext[1] : '0;
      state_q      <= start_mism ? ST_IDLE : ST_RUN;
    end else if (busy_o) begin
      if (run_mism) begin
        state_q      <= ST_IDLE;
        done_o       <= 1'b1;
        fail_s1_o    <= succ[0];
        fail_s2_o    <= succ[1];
        fail_depth_o <= succ_d;
      end else begin
        if (new_pair) visited_q[succ_idx] <= 1'b1;
        sym_q <= last_sym ? '0 : sym_q + 1'b1;
        if (drained || fifo_empty) begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
          equiv_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dfa_eq_check_chk.sv
module dfa_eq_check_chk #(
  parameter int N_STATES = 16,
  localparam int SW = $clog2(N_STATES + 1),
  localparam int DW = $clog2((N_STATES + 1) * (N_STATES + 1))
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          equiv_o,
  input logic [SW-1:0] fail_s1_o,
  input logic [SW-1:0] fail_s2_o,
  input logic [DW-1:0] fail_depth_o
);
  localparam logic [SW-1:0] SINK = SW'(N_STATES);

  // R1
  busy_from_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  // R8
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(equiv_o) && $stable(fail_s1_o)
                              && $stable(fail_s2_o) && $stable(fail_depth_o)));

  // R5
  sink_pair_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !equiv_o) |-> !(fail_s1_o == SINK && fail_s2_o == SINK));

  // R7
  depth0_real_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !equiv_o && fail_depth_o == '0) |-> (fail_s1_o != SINK && fail_s2_o != SINK));

  // R6
  equiv_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && equiv_o) |-> (fail_depth_o == '0 && fail_s1_o == '0 && fail_s2_o == '0));

  // R9
  busy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);
endmodule

bind dfa_eq_check dfa_eq_check_chk #(.N_STATES(N_STATES)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .equiv_o      (equiv_o),
  .fail_s1_o    (fail_s1_o),
  .fail_s2_o    (fail_s2_o),
  .fail_depth_o (fail_depth_o)
);

// File: tb/test_dfa_eq_check.sv
module test_dfa_eq_check;
  localparam int NS = 16;
  localparam int NA = 4;
  localparam int SK = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tr_we = 0, acc_we = 0, wr_mach = 0, wr_spec = 0, wr_acc = 0, start = 0;
  logic [3:0] wr_state = 0, wr_next = 0, st1 = 0, st2 = 0;
  logic [1:0] wr_sym = 0;
  logic busy, done, equiv;
  logic [4:0] f1, f2;
  logic [8:0] fd;

  always #2 clk = ~clk;

  dfa_eq_check i_dfa_eq_check (
    .clk_i(clk), .rst_ni(rst_ni), .tr_we_i(tr_we), .acc_we_i(acc_we), .wr_mach_i(wr_mach),
    .wr_state_i(wr_state), .wr_sym_i(wr_sym), .wr_next_i(wr_next), .wr_spec_i(wr_spec),
    .wr_acc_i(wr_acc), .start_i(start), .start1_i(st1), .start2_i(st2), .busy_o(busy),
    .done_o(done), .equiv_o(equiv), .fail_s1_o(f1), .fail_s2_o(f2), .fail_depth_o(fd));

  int n_chk = 0, n_fail = 0;
  int tt[2][NS][NA];
  bit sp[2][NS][NA];
  bit ac[2][NS];
  bit r_eq; int r1, r2, rd;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sn(int m, int s, int a);
    return (s == SK || !sp[m][s][a]) ? SK : tt[m][s][a];
  endfunction
  function automatic bit sa(int m, int s);
    return (s == SK) ? 1'b0 : ac[m][s];
  endfunction
  function automatic bit bad(int x, int y);
    return ((x == SK) != (y == SK)) || (sa(0, x) != sa(1, y));
  endfunction

  task automatic ref_bfs(int s1, int s2);
    bit vis[SK+1][SK+1];
    int q1[$], q2[$], qd[$];
    for (int i = 0; i <= SK; i++) for (int j = 0; j <= SK; j++) vis[i][j] = 0;
    r_eq = 0; r1 = s1; r2 = s2; rd = 0;
    if (bad(s1, s2)) return;
    vis[s1][s2] = 1; q1.push_back(s1); q2.push_back(s2); qd.push_back(0);
    while (q1.size() > 0) begin
      int x = q1.pop_front(), y = q2.pop_front(), d = qd.pop_front();
      for (int a = 0; a < NA; a++) begin
        int nx = sn(0, x, a), ny = sn(1, y, a);
        if (bad(nx, ny)) begin r1 = nx; r2 = ny; rd = d + 1; return; end
        if (!vis[nx][ny]) begin
          vis[nx][ny] = 1; q1.push_back(nx); q2.push_back(ny); qd.push_back(d + 1);
        end
      end
    end
    r_eq = 1; r1 = 0; r2 = 0; rd = 0;
  endtask

  task automatic load_all();
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < NS; s++) begin
        for (int a = 0; a < NA; a++) begin
          tr_we = 1; wr_mach = 1'(m); wr_state = 4'(s); wr_sym = 2'(a);
          wr_next = 4'(tt[m][s][a]); wr_spec = sp[m][s][a];
          @(negedge clk);
        end
        tr_we = 0; acc_we = 1; wr_acc = ac[m][s];
        @(negedge clk);
        acc_we = 0;
      end
    end
  endtask

  task automatic pulse_start(int s1, int s2);
    st1 = 4'(s1); st2 = 4'(s2); start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
  endtask

  task automatic run_cmp(string req, int s1, int s2);
    ref_bfs(s1, s2);
    pulse_start(s1, s2);
    wait_done();
    chk(done == 1, req, "done", done, 1);
    chk(equiv == r_eq, req, "equiv", equiv, r_eq);
    chk(f1 == r1 && f2 == r2, req, "fail pair (s1*32+s2)", f1 * 32 + f2, r1 * 32 + r2);
    chk(fd == rd, req, "depth", fd, rd);
  endtask

  task automatic rand_machine(int m, bit full);
    for (int s = 0; s < NS; s++) begin
      ac[m][s] = 1'($urandom_range(0, 1));
      for (int a = 0; a < NA; a++) begin
        tt[m][s][a] = $urandom_range(0, NS - 1);
        sp[m][s][a] = full ? 1'b1 : ($urandom_range(0, 7) != 0);
      end
    end
  endtask

  // second machine as a relabelled copy of the first; returns image of s
  task automatic perm_copy(output int pm[NS]);
    for (int i = 0; i < NS; i++) pm[i] = i;
    for (int i = NS - 1; i > 0; i--) begin
      int j = $urandom_range(0, i); int t = pm[i]; pm[i] = pm[j]; pm[j] = t;
    end
    for (int s = 0; s < NS; s++) begin
      ac[1][pm[s]] = ac[0][s];
      for (int a = 0; a < NA; a++) begin
        tt[1][pm[s]][a] = pm[tt[0][s][a]];
        sp[1][pm[s]][a] = sp[0][s][a];
      end
    end
  endtask

  task automatic t_reset();
    chk(busy == 0 && done == 0 && equiv == 0, "R10", "status after reset", {busy, done, equiv}, 0);
    chk(f1 == 0 && f2 == 0 && fd == 0, "R10", "fail fields after reset", f1 + f2 + fd, 0);
    pulse_start(3, 5);
    chk(done == 0 && busy == 1, "R10", "all-unspecified start pair not a mismatch", {busy, done}, 2);
    wait_done();
    chk(equiv == 1, "R10", "reset tables equivalent", equiv, 1);
  endtask

  task automatic t_start_mismatch();
    int pm[NS];
    rand_machine(0, 1); perm_copy(pm);
    ac[1][pm[2]] = ~ac[0][2];
    load_all();
    pulse_start(2, pm[2]);
    chk(done == 1 && busy == 0, "R7", "done one cycle after strobe", {busy, done}, 1);
    chk(equiv == 0 && fd == 0, "R7", "depth 0 mismatch", fd, 0);
    chk(f1 == 2 && f2 == pm[2], "R7", "start pair reported", f1 * 32 + f2, 2 * 32 + pm[2]);
  endtask

  task automatic t_permuted(int k);
    int pm[NS];
    for (int it = 0; it < k; it++) begin
      int s;
      rand_machine(0, it[0]); perm_copy(pm); load_all();
      s = $urandom_range(0, NS - 1);
      run_cmp("R6", s, pm[s]);
      chk(equiv == 1, "R2", "permuted copy equivalent", equiv, 1);
    end
  endtask

  task automatic t_flip(int k);
    int pm[NS];
    for (int it = 0; it < k; it++) begin
      int s, v;
      rand_machine(0, 1); perm_copy(pm);
      v = $urandom_range(0, NS - 1); ac[1][v] = ~ac[1][v];
      load_all();
      s = $urandom_range(0, NS - 1);
      run_cmp("R4", s, pm[s]);
    end
  endtask

  task automatic t_random(int k);
    for (int it = 0; it < k; it++) begin
      rand_machine(0, 0); rand_machine(1, 0); load_all();
      run_cmp("R3", $urandom_range(0, NS - 1), $urandom_range(0, NS - 1));
    end
  endtask

  task automatic t_sink();
    int s;
    rand_machine(0, 1);
    ac[1] = ac[0]; tt[1] = tt[0]; sp[1] = sp[0];
    s = 4;
    sp[0][s][0] = 0; sp[1][s][0] = 0;
    load_all();
    run_cmp("R5", s, s);
    chk(equiv == 1, "R5", "both into sink together", equiv, 1);
    sp[1][s][0] = 1;
    load_all();
    run_cmp("R5", s, s);
    chk(equiv == 0 && f1 == SK && f2 == tt[1][s][0] && fd == 1, "R5",
        "one-sided sink at depth 1 (s1*32+s2)", f1 * 32 + f2, SK * 32 + tt[1][s][0]);
  endtask

  task automatic t_busy_ignore();
    int pm[NS];
    rand_machine(0, 1); perm_copy(pm); load_all();
    ref_bfs(1, pm[1]);
    pulse_start(1, pm[1]);
    chk(busy == 1 && done == 0, "R1", "busy after strobe, done cleared", {busy, done}, 2);
    acc_we = 1; wr_mach = 0; wr_state = 4'd1; wr_acc = ~ac[0][1];
    start = 1; st1 = 4'd0; st2 = 4'd0;
    @(negedge clk);
    acc_we = 0; start = 0;
    wait_done();
    chk(equiv == 1, "R9", "mid-search strobe/write ignored", equiv, 1);
    repeat (5) @(negedge clk);
    chk(done == 1 && equiv == 1 && fd == 0, "R8", "result held", {done, equiv}, 3);
    run_cmp("R9", 1, pm[1]);
    chk(equiv == 1, "R9", "table unchanged by busy write", equiv, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_start_mismatch();
    t_permuted(4);
    t_flip(6);
    t_random(6);
    t_sink();
    t_busy_ignore();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule